// File: doc/BRIEF.md
# External Sync Pulse Supervisor

This block watches an asynchronous external synchronization line. It brings the line into the system clock domain and turns each rising edge into a single-cycle tick. It keeps a running count of those ticks, which the host can read and clear. The tick also restarts a down-counting period timer.

The period timer is meant to be programmed slightly longer than the expected external sync period. While ticks keep arriving on time, each one reloads the timer before it can run out. If the timer does run out, a tick was missed. The block then emits a one-cycle expiry pulse and stretches it into a long out-of-sync indicator. Each tick is also stretched into a visible sync indicator.

The host reaches the controls, the tick count and the live timer value through a small register port. Writes are single-cycle and reads are combinational. The timer is a two-state machine. In TMR_IDLE it holds zero. It moves to TMR_RUN on a load event when the programmed length is non-zero. It goes back to TMR_IDLE on a load event or expiry that finds a zero length. Each indicator stretcher is a two-state machine. It moves from STR_QUIET to STR_HOLD on a trigger, restarts its hold count on every further trigger, and returns to STR_QUIET when the count runs out.

Top module: `sync_pulse_supervisor`

## Requirements
- R1: The external input passes through a chain of SYNC_STAGES flip-flops (default 2) and an edge stage. Each low-to-high transition yields exactly one cycle of `sync_pulse_o`. A falling edge or a steady level yields none.
- R2: A CNT_W-bit tick counter (default 32) increments once per tick. It reads zero-extended at address 1 and wraps from all ones to zero.
- R3: Control bit 8 (address 0) clears the tick counter. While the bit is set, the counter holds zero and ticks are not counted. Reset also clears the counter.
- R4: Address 2 holds the timer length in bits 30:0 and a start request in bit 31. The timer reloads the length on a tick or on a rising edge of the start bit. The start bit passes through the same synchronizer and edge stage as the external input, so a start bit held high causes no further reload.
- R5: A running timer decrements once per cycle. In the cycle after it reads zero, `expire_o` is high for exactly one cycle and the length has been reloaded, so the expiry period is length+1 cycles. A load event in the same cycle wins over both the decrement and the expiry.
- R6: After reset the timer is idle and reads zero. A load event or expiry that finds a length of zero also makes it idle. An idle timer never expires.
- R7: `oos_ind_o` goes high in the cycle after each expiry pulse and stays high for STRETCH_LEN cycles (default 1,000,000). A new expiry restarts the full period.
- R8: `sync_ind_o` goes high in the cycle after each tick and stays high for STRETCH_LEN cycles. A new tick restarts the full period.
- R9: At address 0, bits 0 to 3 drive `term_en_o`, `dir_o`, `drive_en_o` and `test_n_o`. Bits 0 to 3 and bit 8 read back as written. All other bits of that address read zero.
- R10: Address 3 reads the live timer value. Writes to addresses 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sync_i | input | 1 | Asynchronous external sync line |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| term_en_o | output | 1 | Termination enable control |
| dir_o | output | 1 | Direction control |
| drive_en_o | output | 1 | Output drive enable control |
| test_n_o | output | 1 | Active-low test control |
| sync_pulse_o | output | 1 | One-cycle tick per rising edge |
| expire_o | output | 1 | One-cycle timer expiry pulse |
| sync_ind_o | output | 1 | Stretched sync indicator |
| oos_ind_o | output | 1 | Stretched out-of-sync indicator |

## Verification
The bench holds the start bit high across many cycles. A design that reloads on the level instead of the edge would never count down, and would fail the timer readback. Ticks are sent faster than the timer period. A design that let the decrement or the expiry win over a tick reload would produce expiry pulses. Zero-length loads check that the timer parks instead of expiring every cycle. Closely spaced triggers check that a stretcher restarts its hold rather than ending early. A narrow-counter copy runs past all ones to show the wrap to zero. Random mixes of edges and register writes are compared cycle by cycle against a port-level model.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic {TMR_IDLE, TMR_RUN} tmr_state_e;
    typedef enum logic {STR_QUIET, STR_HOLD} str_state_e;

    localparam logic [1:0] ADDR_CTL    = 2'd0;
    localparam logic [1:0] ADDR_COUNT  = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;
    localparam logic [1:0] ADDR_TIMER  = 2'd3;

    localparam int CTL_TERM_BIT  = 0;
    localparam int CTL_DIR_BIT   = 1;
    localparam int CTL_DRV_BIT   = 2;
    localparam int CTL_TEST_BIT  = 3;
    localparam int CTL_CLR_BIT   = 8;
    localparam int PERIOD_START_BIT = 31;

    typedef struct packed {
        logic term_en;
        logic dir;
        logic drive_en;
        logic test_n;
        logic clr;
    } ctl_t;

endpackage

// File: rtl/sps_edge_sync.sv
module sps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        pulse_o = chain_q[STAGES-1] & ~last_q;
    end
endmodule

// File: rtl/sps_pulse_counter.sv
module sps_pulse_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr) begin
            count_o <= '0;
        end else if (inc) begin
            count_o <= count_o + ONE;
        end
    end
endmodule

// File: rtl/sps_period_timer.sv
module sps_period_timer
    import sps_pkg::*;
#(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic [W-1:0] count_o,
    output logic         expire_o,
    output logic         running_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    tmr_state_e   st_q, st_n;
    logic [W-1:0] cnt_n;
    logic         exp_n;
    logic         len_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= TMR_IDLE;
            count_o  <= '0;
            expire_o <= 1'b0;
        end else begin
            st_q     <= st_n;
            count_o  <= cnt_n;
            expire_o <= exp_n;
        end
    end

    always_comb begin
        len_zero = (len == '0);
        st_n     = st_q;
        cnt_n    = count_o;
        exp_n    = 1'b0;
        unique case (st_q)
            TMR_IDLE: begin
                if (load && !len_zero) begin
                    st_n  = TMR_RUN;
                    cnt_n = len;
                end
            end
            TMR_RUN: begin
                if (load) begin
                    st_n  = len_zero ? TMR_IDLE : TMR_RUN;
                    cnt_n = len;
                end else if (count_o == '0) begin
                    exp_n = 1'b1;
                    st_n  = len_zero ? TMR_IDLE : TMR_RUN;
                    cnt_n = len;
                end else begin
                    cnt_n = count_o - ONE;
                end
            end
            default: begin
                st_n  = TMR_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        running_o = (st_q == TMR_RUN);
    end
endmodule

// File: rtl/sps_pulse_stretch.sv
module sps_pulse_stretch
    import sps_pkg::*;
#(
    parameter int LEN = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic out_o
);
    localparam int            CW    = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);
    localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};

    str_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= STR_QUIET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            STR_QUIET: begin
                if (trig) begin
                    st_n  = STR_HOLD;
                    cnt_n = LEN_V;
                end
            end
            STR_HOLD: begin
                if (trig) begin
                    cnt_n = LEN_V;
                end else if (cnt_q == ONE) begin
                    st_n  = STR_QUIET;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            default: begin
                st_n  = STR_QUIET;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        out_o = (st_q == STR_HOLD);
    end
endmodule

// File: rtl/sps_regs.sv
module sps_regs
    import sps_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TMR_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             we,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] count,
    input  logic [TMR_W-1:0] timer,
    output ctl_t             ctl_o,
    output logic [TMR_W-1:0] len_o,
    output logic             start_o,
    output logic [31:0]      rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o   <= '0;
            len_o   <= '0;
            start_o <= 1'b0;
        end else if (we) begin
            unique case (addr)
                ADDR_CTL: begin
                    ctl_o.term_en  <= wdata[CTL_TERM_BIT];
                    ctl_o.dir      <= wdata[CTL_DIR_BIT];
                    ctl_o.drive_en <= wdata[CTL_DRV_BIT];
                    ctl_o.test_n   <= wdata[CTL_TEST_BIT];
                    ctl_o.clr      <= wdata[CTL_CLR_BIT];
                end
                ADDR_PERIOD: begin
                    len_o   <= wdata[TMR_W-1:0];
                    start_o <= wdata[PERIOD_START_BIT];
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTL: begin
                rdata[CTL_TERM_BIT] = ctl_o.term_en;
                rdata[CTL_DIR_BIT]  = ctl_o.dir;
                rdata[CTL_DRV_BIT]  = ctl_o.drive_en;
                rdata[CTL_TEST_BIT] = ctl_o.test_n;
                rdata[CTL_CLR_BIT]  = ctl_o.clr;
            end
            ADDR_COUNT:  rdata = 32'(count);
            ADDR_PERIOD: begin
                rdata[TMR_W-1:0]        = len_o;
                rdata[PERIOD_START_BIT] = start_o;
            end
            ADDR_TIMER:  rdata = 32'(timer);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/sync_pulse_supervisor.sv
module sync_pulse_supervisor
    import sps_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 32,
    parameter int TMR_W       = 31,
    parameter int STRETCH_LEN = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_sync_i,
    input  logic [1:0]  reg_addr_i,
    input  logic        reg_we_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        term_en_o,
    output logic        dir_o,
    output logic        drive_en_o,
    output logic        test_n_o,
    output logic        sync_pulse_o,
    output logic        expire_o,
    output logic        sync_ind_o,
    output logic        oos_ind_o
);
    ctl_t             ctl_q;
    logic [TMR_W-1:0] tmr_len;
    logic             start_lvl;
    logic             start_p;
    logic             sync_p;
    logic             tmr_load;
    logic             tmr_run;
    logic             ctl_clr;
    logic [CNT_W-1:0] pulse_cnt;
    logic [TMR_W-1:0] tmr_cnt;

    sps_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_sync_i), .pulse_o(sync_p)
    );

    sps_edge_sync #(.STAGES(SYNC_STAGES)) u_start_edge (
        .clk(clk), .rst_n(rst_n), .din(start_lvl), .pulse_o(start_p)
    );

    sps_pulse_counter #(.W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(sync_p), .clr(ctl_clr), .count_o(pulse_cnt)
    );

    sps_period_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
        .count_o(tmr_cnt), .expire_o(expire_o), .running_o(tmr_run)
    );

    sps_pulse_stretch #(.LEN(STRETCH_LEN)) u_sync_ind (
        .clk(clk), .rst_n(rst_n), .trig(sync_p), .out_o(sync_ind_o)
    );

    sps_pulse_stretch #(.LEN(STRETCH_LEN)) u_oos_ind (
        .clk(clk), .rst_n(rst_n), .trig(expire_o), .out_o(oos_ind_o)
    );

    sps_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr_i), .we(reg_we_i),
        .wdata(reg_wdata_i), .count(pulse_cnt), .timer(tmr_cnt),
        .ctl_o(ctl_q), .len_o(tmr_len), .start_o(start_lvl), .rdata(reg_rdata_o)
    );

    always_comb begin
        tmr_load     = sync_p | start_p;
        ctl_clr      = ctl_q.clr;
        sync_pulse_o = sync_p;
        term_en_o    = ctl_q.term_en;
        dir_o        = ctl_q.dir;
        drive_en_o   = ctl_q.drive_en;
        test_n_o     = ctl_q.test_n;
    end
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_p,
    input logic             start_p,
    input logic             expire,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic [TMR_W-1:0] len,
    input logic [TMR_W-1:0] timer,
    input logic             sync_ind,
    input logic             oos_ind
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_p |=> !sync_p); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_p && !clr) |=> (count == $past(count) + ONE)); // R2
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R3
    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_p || start_p) && len != '0) |=> (timer == $past(len))); // R4
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R5
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> ($past(timer) == '0)); // R5
    AST_ZERO_LEN_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_p || start_p) && len == '0) |=> (timer == '0)); // R6
    AST_OOS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> oos_ind); // R7
    AST_SYNC_IND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_p |=> sync_ind); // R8
endmodule

bind sync_pulse_supervisor sps_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_p(sync_p), .start_p(start_p),
    .expire(expire_o), .clr(ctl_clr), .count(pulse_cnt), .len(tmr_len),
    .timer(tmr_cnt), .sync_ind(sync_ind_o), .oos_ind(oos_ind_o)
);

// File: tb/sync_pulse_supervisor_tb.sv
`timescale 1ns/1ps
module sync_pulse_supervisor_tb;
    localparam int STRETCH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata, rdata_w;
    logic        term_en, dir, drv, test_n, spulse, expire, sind, oind;
    logic        w_t, w_d, w_e, w_x, w_sp, w_ex, w_si, w_oi;

    int total = 0;
    int fails = 0;
    int n_sp = 0;
    int n_exp = 0;
    int n_si = 0;
    int n_oi = 0;
    logic [31:0] v1, v2;

    always #2.5 clk = ~clk;

    sync_pulse_supervisor #(.STRETCH_LEN(STRETCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_sync_i(ext), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .term_en_o(term_en), .dir_o(dir), .drive_en_o(drv), .test_n_o(test_n),
        .sync_pulse_o(spulse), .expire_o(expire), .sync_ind_o(sind), .oos_ind_o(oind)
    );

    sync_pulse_supervisor #(.CNT_W(4), .STRETCH_LEN(STRETCH)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .ext_sync_i(ext), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata_w),
        .term_en_o(w_t), .dir_o(w_d), .drive_en_o(w_e), .test_n_o(w_x),
        .sync_pulse_o(w_sp), .expire_o(w_ex), .sync_ind_o(w_si), .oos_ind_o(w_oi)
    );

    // port-level reference model built from the requirements
    logic        m_s0, m_s1, m_sd, m_t0, m_t1, m_td;
    logic [31:0] m_cnt;
    logic [3:0]  m_ctl;
    logic        m_clr, m_start, m_run, m_exp;
    logic [30:0] m_len, m_tmr;
    int          m_si, m_oi;
    wire m_sp   = m_s1 & ~m_sd;
    wire m_load = m_sp | (m_t1 & ~m_td);

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s0, m_s1, m_sd, m_t0, m_t1, m_td} <= '0;
            m_cnt <= '0; m_ctl <= '0; m_clr <= 1'b0; m_start <= 1'b0;
            m_len <= '0; m_run <= 1'b0; m_tmr <= '0; m_exp <= 1'b0;
            m_si <= 0; m_oi <= 0;
        end else begin
            m_s0 <= ext; m_s1 <= m_s0; m_sd <= m_s1;
            m_t0 <= m_start; m_t1 <= m_t0; m_td <= m_t1;
            if (we && addr == 2'd0) begin m_ctl <= wdata[3:0]; m_clr <= wdata[8]; end
            if (we && addr == 2'd2) begin m_len <= wdata[30:0]; m_start <= wdata[31]; end
            m_cnt <= m_clr ? 32'd0 : m_cnt + {31'd0, m_sp};
            m_exp <= 1'b0;
            if (m_load) begin
                m_run <= (m_len != 0); m_tmr <= m_len;
            end else if (m_run && m_tmr == 0) begin
                m_exp <= 1'b1; m_run <= (m_len != 0); m_tmr <= m_len;
            end else if (m_run) begin
                m_tmr <= m_tmr - 31'd1;
            end
            m_si <= m_sp  ? STRETCH : (m_si > 0 ? m_si - 1 : 0);
            m_oi <= m_exp ? STRETCH : (m_oi > 0 ? m_oi - 1 : 0);
        end
    end

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {23'd0, m_clr, 4'd0, m_ctl};
            2'd1:    return m_cnt;
            2'd2:    return {m_start, m_len};
            default: return {1'b0, m_tmr};
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (spulse) n_sp++;
            if (expire) n_exp++;
            if (sind)   n_si++;
            if (oind)   n_oi++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext = 1'b1;
        repeat (4) @(negedge clk);
        ext = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed, b0, b1, gap;
        seed = $urandom(32'd2024);
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v1); chk("R6 reset read", v1, 32'd0);
        end
        chk("R9 reset outputs", {28'd0, term_en, dir, drv, test_n}, 32'd0);
        chk("R8 reset indicators", {29'd0, spulse, sind, oind}, 32'd0);

        // R9 control readback
        wr(2'd0, 32'h0000_010F);
        rd(2'd0, v1); chk("R9 ctl readback", v1, 32'h0000_010F);
        chk("R9 ctl outputs", {28'd0, term_en, dir, drv, test_n}, 32'hF);
        // R3 clear held: ticks not counted
        pulse_ext(); pulse_ext();
        rd(2'd1, v1); chk("R3 clear holds zero", v1, 32'd0);
        wr(2'd0, 32'hFFFF_FEF0);
        rd(2'd0, v1); chk("R9 other bits read zero", v1, 32'd0);
        chk("R9 ctl outputs low", {28'd0, term_en, dir, drv, test_n}, 32'h0);

        // R2 counting and wrap of the narrow copy
        for (int i = 0; i < 18; i++) pulse_ext();
        idle(4);
        rd(2'd1, v1); chk("R2 count", v1, 32'd18);
        addr = 2'd1; #1 chk("R2 wrap", rdata_w, 32'd2);

        // R1 one pulse per rising edge
        b0 = n_sp; pulse_ext(); idle(6);
        chk("R1 single tick", n_sp - b0, 32'd1);
        b0 = n_sp; ext = 1'b1; idle(20);
        chk("R1 steady level no extra tick", n_sp - b0, 32'd1);
        ext = 1'b0; idle(20);
        chk("R1 falling edge no tick", n_sp - b0, 32'd1);

        // R8 sync indicator stretch and retrigger
        b0 = n_si; pulse_ext(); idle(30);
        chk("R8 stretch length", n_si - b0, STRETCH);
        b0 = n_si; pulse_ext(); pulse_ext(); idle(30);
        chk("R8 retrigger", n_si - b0, STRETCH + 8);

        // R10 read-only addresses
        rd(2'd1, v1);
        wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, v2); chk("R10 count write ignored", v2, v1);
        rd(2'd3, v2); chk("R10 timer write ignored", v2, 32'd0);

        // R7 single expiry stretch
        wr(2'd2, 32'd40); wr(2'd2, 32'h8000_0028);
        gap = 0;
        while (!expire && gap < 200) begin @(negedge clk); gap++; end
        b0 = n_oi; idle(30);
        chk("R7 oos stretch", n_oi - b0, STRETCH);

        // R5 expiry period length+1
        wr(2'd2, 32'd5); wr(2'd2, 32'h8000_0005);
        idle(50);
        gap = 0;
        while (!expire && gap < 200) begin @(negedge clk); gap++; end
        gap = 0;
        @(negedge clk);
        while (!expire && gap < 200) begin @(negedge clk); gap++; end
        chk("R5 expiry period", gap + 1, 32'd6);

        // R6 zero length parks the timer
        wr(2'd2, 32'd0); wr(2'd2, 32'h8000_0000);
        idle(8);
        b0 = n_exp; idle(30);
        chk("R6 no expiry when idle", n_exp - b0, 32'd0);
        rd(2'd3, v1); chk("R6 idle timer reads zero", v1, 32'd0);

        // R4 held start level does not reload
        wr(2'd2, 32'd30); wr(2'd2, 32'h8000_001E);
        idle(6);
        rd(2'd3, v1); idle(5); rd(2'd3, v2);
        chk("R4 held start counts down", v2, v1 - 32'd5);

        // R4/R5 ticks reload before expiry
        wr(2'd2, 32'd20); wr(2'd2, 32'h8000_0014);
        b0 = n_exp;
        for (int i = 0; i < 10; i++) pulse_ext();
        chk("R5 reload wins over expiry", n_exp - b0, 32'd0);

        // random phase against the model
        b1 = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom % 6 == 0) ext = ~ext;
            we = ($urandom % 10 == 0);
            addr = 2'($urandom % 4);
            if (addr == 2'd2) wdata = {$urandom % 2 == 0, 27'd0, 4'($urandom % 16)};
            else wdata = {23'd0, $urandom % 4 == 0, 4'd0, 4'($urandom % 16)};
            #1;
            chk("R1 random tick", {31'd0, spulse}, {31'd0, m_sp});
            chk("R5 random expiry", {31'd0, expire}, {31'd0, m_exp});
            chk("R8 random sync ind", {31'd0, sind}, {31'd0, m_si != 0});
            chk("R7 random oos ind", {31'd0, oind}, {31'd0, m_oi != 0});
            chk("R10 random read", rdata, exp_read(addr));
            if (addr == 2'd1) chk("R2 random narrow count", rdata_w, {28'd0, m_cnt[3:0]});
            if (m_sp) b1++;
        end
        we = 1'b0;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule